// File: doc/BRIEF.md
# Tiled Block RAM

This block is a parameterised on-chip memory assembled entirely from one fixed storage tile that holds 256 words of 9 bits. Tiles are laid side by side until the word is wide enough. Each tile carries one 9-bit slice of the word, and all tiles in a row share the address, write enable and clock. Rows of tiles are stacked to reach the requested depth. The upper address bits pick the row that takes a write and the row that supplies read data.

Three read timings are selectable by parameter: a combinational read, a clocked read with write-through, and a clocked read followed by an extra output register. A second parameter selects the single-port form, where one address serves both write and read, or the simple dual-port form, which has one write address and one independent read address on a shared clock. Addresses at or above the configured depth are never written. Words narrower than a whole number of tiles are zero-padded in the unused tile bits.

Top module: `tiled_ram`

## Requirements
- R1: The storage is built from tiles of 256 x 9 bits, with ceil(WIDTH/9) tiles per row and ceil(DEPTH/256) rows. Every WIDTH-bit word written at an address below DEPTH reads back unchanged.
- R2: When `we` is high at a rising clock edge, `wdata` is stored at `waddr`. The tile row is waddr/256 and the word within the tile is waddr mod 256. Only that row is write-enabled, and no other stored word changes.
- R3: With RD_MODE = RD_ASYNC (encoding 0), `rdata` shows the word at the read address in the same cycle, including writes committed on earlier edges.
- R4: With RD_MODE = RD_SYNC_THRU (encoding 1), `rdata` loads at each rising edge the word at the read address sampled at that edge, giving one cycle of latency. If that edge also writes the same address, the newly written data is returned.
- R5: With RD_MODE = RD_SYNC_REG (encoding 2), the word that RD_SYNC_THRU would present after one edge appears on `rdata` one edge later, giving two cycles of latency. The same write-through rule applies.
- R6: With DUAL = 1, reads use `raddr` independently of `waddr`. With DUAL = 0, `waddr` addresses both write and read, and `raddr` has no effect on `rdata`.
- R7: A write to any address at or above DEPTH changes no stored word.
- R8: While `rst_n` is low (asynchronous, active low), `rdata` is zero in RD_SYNC_THRU and RD_SYNC_REG modes. Stored words are kept across reset.
- R9: The row choice that steers the read multiplexer is delayed to line up with the tile read latency. Back-to-back reads that hop between rows return the correct word on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and clocked reads |
| rst_n | input | 1 | Asynchronous active-low reset of read registers |
| we | input | 1 | Write enable |
| waddr | input | AW = clog2(DEPTH) | Write address; also the read address when DUAL = 0 |
| wdata | input | WIDTH | Write data |
| raddr | input | AW | Read address when DUAL = 1; ignored when DUAL = 0 |
| rdata | output | WIDTH | Read data, timed by RD_MODE |

## Verification
The hardest situation to reach is a read whose row choice changes on every cycle while writes land in the same or another row. A row-select register that is off by one cycle then returns a neighbouring row's word. The stimulus walks the read address round a list that crosses all three rows of a 600-deep, 20-bit memory. It also forces the write and read addresses to coincide so that write-through is exercised in both clocked modes. Out-of-range writes are followed by a full sweep of every valid address, so that any corruption becomes visible at the read port.

// File: rtl/tram_pkg.sv
package tram_pkg;

  localparam int unsigned TILE_WORDS = 256;
  localparam int unsigned TILE_BITS  = 9;
  localparam int unsigned TILE_AW    = 8;

  typedef enum logic [1:0] {
    RD_ASYNC     = 2'd0,
    RD_SYNC_THRU = 2'd1,
    RD_SYNC_REG  = 2'd2
  } rd_mode_e;

  function automatic int unsigned tiles_across(int unsigned width);
    return (width + TILE_BITS - 1) / TILE_BITS;
  endfunction

  function automatic int unsigned tiles_down(int unsigned depth);
    return (depth + TILE_WORDS - 1) / TILE_WORDS;
  endfunction

  function automatic int unsigned tile_row(logic [31:0] addr);
    return addr / TILE_WORDS;
  endfunction

  function automatic logic [TILE_AW-1:0] tile_offset(logic [31:0] addr);
    return TILE_AW'(addr % TILE_WORDS);
  endfunction

  function automatic int unsigned sel_stages(rd_mode_e mode);
    return (mode == RD_ASYNC) ? 0 : 1;
  endfunction

endpackage

// File: rtl/tram_tile.sv
module tram_tile #(
  parameter bit SYNC_RD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wa,
  input  logic [8:0] wd,
  input  logic [7:0] ra,
  output logic [8:0] rq
);

  logic [8:0] cells [256];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
  end

  generate
    if (SYNC_RD) begin : g_sync
      logic [8:0] rq_r;
      logic       hit_now;
      assign hit_now = we && (wa == ra);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rq_r <= '0;
        else if (hit_now) rq_r <= wd;
        else              rq_r <= cells[ra];
      end
      assign rq = rq_r;

      // R4 / R5: a same-address write shows up on the tile output next cycle
      assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == ra) |=> (rq == $past(wd)));
    end else begin : g_async
      logic unused_rst;
      assign unused_rst = rst_n;
      assign rq = cells[ra];
    end
  endgenerate

endmodule

// File: rtl/tram_delay.sv
module tram_delay #(
  parameter int unsigned STAGES = 1,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tiled_ram.sv
module tiled_ram
  import tram_pkg::*;
#(
  parameter int unsigned DEPTH   = 600,
  parameter int unsigned WIDTH   = 20,
  parameter rd_mode_e    RD_MODE = RD_SYNC_THRU,
  parameter bit          DUAL    = 1'b1,
  localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  localparam int unsigned COLS   = tiles_across(WIDTH);
  localparam int unsigned ROWS   = tiles_down(DEPTH);
  localparam int unsigned PADW   = COLS * TILE_BITS;
  localparam int unsigned RIW    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned SEL_DL = sel_stages(RD_MODE);
  localparam bit          SYNC   = (RD_MODE != RD_ASYNC);

  // ---- named internal events ----
  logic [AW-1:0]      rd_addr_eff;
  logic               wr_in_range;
  logic               rd_in_range;
  logic [RIW-1:0]     rd_row;
  logic [ROWS-1:0]    row_we;
  logic [7:0]         wr_off;
  logic [7:0]         rd_off;
  logic [PADW-1:0]    wdata_pad;
  logic [PADW-1:0]    row_q [ROWS];
  logic               sel_valid;
  logic [RIW-1:0]     sel_row;
  logic [PADW-1:0]    sel_word;
  logic               primed;

  generate
    if (DUAL) begin : g_dual
      assign rd_addr_eff = raddr;
    end else begin : g_single
      logic unused_raddr;
      assign unused_raddr = ^raddr;
      assign rd_addr_eff  = waddr;
    end
  endgenerate

  assign wr_in_range = 32'(waddr) < 32'(DEPTH);
  assign rd_in_range = 32'(rd_addr_eff) < 32'(DEPTH);
  assign rd_row      = RIW'(tile_row(32'(rd_addr_eff)));
  assign wr_off      = tile_offset(32'(waddr));
  assign rd_off      = tile_offset(32'(rd_addr_eff));

  always_comb begin
    wdata_pad = '0;
    wdata_pad[WIDTH-1:0] = wdata;
  end

  // ---- depth decode and tile array ----
  generate
    for (genvar r = 0; r < int'(ROWS); r++) begin : g_row
      assign row_we[r] = we && wr_in_range && (tile_row(32'(waddr)) == r);
      for (genvar c = 0; c < int'(COLS); c++) begin : g_col
        tram_tile #(.SYNC_RD(SYNC)) u_tile (
          .clk  (clk),
          .rst_n(rst_n),
          .we   (row_we[r]),
          .wa   (wr_off),
          .wd   (wdata_pad[c*TILE_BITS +: TILE_BITS]),
          .ra   (rd_off),
          .rq   (row_q[r][c*TILE_BITS +: TILE_BITS])
        );
      end
    end
  endgenerate

  // ---- row select aligned to tile read latency ----
  generate
    if (SEL_DL == 0) begin : g_sel_comb
      assign sel_valid = rd_in_range;
      assign sel_row   = rd_row;
    end else begin : g_sel_pipe
      tram_delay #(.STAGES(SEL_DL), .W(RIW + 1)) u_sel_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rd_in_range, rd_row}),
        .q    ({sel_valid, sel_row})
      );
    end
  endgenerate

  always_comb begin
    sel_word = '0;
    if (sel_valid) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        if (sel_row == RIW'(r)) sel_word = row_q[r];
      end
    end
  end

  generate
    if (PADW > WIDTH) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^sel_word[PADW-1:WIDTH];
    end
  endgenerate

  // ---- output stage ----
  generate
    if (RD_MODE == RD_SYNC_REG) begin : g_outreg
      logic [WIDTH-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= sel_word[WIDTH-1:0];
      end
      assign rdata = out_q;
    end else begin : g_outdir
      assign rdata = sel_word[WIDTH-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // ---- assertions ----
  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we));

  assert_no_oob_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (32'(waddr) >= 32'(DEPTH))) |-> (row_we == '0));

  generate
    if (SEL_DL != 0) begin : g_sel_chk
      assert_sel_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ({sel_valid, sel_row} == $past({rd_in_range, rd_row})));
    end
  endgenerate

endmodule

// File: tb/tiled_ram_test.sv
module tiled_ram_test;

  localparam int D  = 600;
  localparam int W  = 20;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  q_thru, q_async, q_reg;

  tiled_ram #(.DEPTH(D), .WIDTH(W), .RD_MODE(tram_pkg::RD_SYNC_THRU), .DUAL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(q_thru));

  tiled_ram #(.DEPTH(D), .WIDTH(W), .RD_MODE(tram_pkg::RD_ASYNC), .DUAL(1'b1)) uut_sa (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(q_async));

  tiled_ram #(.DEPTH(D), .WIDTH(W), .RD_MODE(tram_pkg::RD_SYNC_REG), .DUAL(1'b0)) uut_sr (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(q_reg));

  // behavioural reference
  logic [W-1:0] mem [D];
  logic [W-1:0] exp_thru, exp_reg, reg_stage;
  bit           reg_stage_ok, exp_reg_ok;
  int           checks = 0, errors = 0;
  bit           cmp_on = 0;
  bit           done = 0;
  string        tag = "R1";

  task automatic check(string t, string what, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      exp_thru = '0; exp_reg = '0; reg_stage = '0;
      reg_stage_ok = 1; exp_reg_ok = 1;
    end else begin
      exp_thru   = (we && waddr == raddr) ? wdata : mem[raddr];
      exp_reg    = reg_stage;
      exp_reg_ok = reg_stage_ok;
      if (int'(waddr) < D) begin
        reg_stage    = we ? wdata : mem[waddr];
        reg_stage_ok = 1;
      end else begin
        reg_stage_ok = 0;
      end
      if (we && int'(waddr) < D) mem[waddr] = wdata;
    end
    @(negedge clk);
    if (cmp_on) begin
      check(tag, "sync-thru", q_thru, exp_thru);
      check(tag, "async", q_async, mem[raddr]);
      if (exp_reg_ok) check(tag, "sync-reg", q_reg, exp_reg);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hop [6] = '{5, 261, 517, 250, 300, 599};
    rst_n = 1'b0; we = 1'b0; waddr = '0; raddr = '0; wdata = '0;
    repeat (3) step();
    // R8: reset state of clocked read paths
    check("R8", "sync-thru reset", q_thru, '0);
    check("R8", "sync-reg reset", q_reg, '0);
    rst_n = 1'b1;

    // R1: fill every word across all tile columns and rows
    cmp_on = 1; tag = "R1";
    for (int a = 0; a < D; a++) begin
      we = 1'b1; waddr = AW'(a); raddr = '0;
      wdata = W'(a * 1237 + 32'h5A5A5);
      step();
    end
    we = 1'b0;
    for (int a = 0; a < D; a++) begin
      waddr = AW'(a); raddr = AW'(D - 1 - a);
      step();
    end

    // R2: random writes and reads in all rows
    tag = "R2";
    for (int i = 0; i < 1500; i++) begin
      we = 1'($urandom); waddr = AW'($urandom % D); raddr = AW'($urandom % D);
      wdata = W'($urandom);
      step();
    end

    // R3: read address sweeps while writes land elsewhere
    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      raddr = AW'(i * 7 % D); we = 1'b1; waddr = AW'((i * 7 + 300) % D);
      wdata = W'($urandom);
      step();
    end

    // R4: same-address write and read (write-through)
    tag = "R4";
    for (int i = 0; i < 64; i++) begin
      we = 1'b1; waddr = AW'($urandom % D); raddr = waddr; wdata = W'($urandom);
      step();
    end

    // R5: two-cycle registered read, mixed writes at the shared address
    tag = "R5";
    for (int i = 0; i < 200; i++) begin
      we = 1'(i % 3 == 0); waddr = AW'($urandom % D); raddr = AW'($urandom % D);
      wdata = W'($urandom);
      step();
    end

    // R6: single-port instance must ignore raddr
    tag = "R6";
    for (int i = 0; i < 200; i++) begin
      we = 1'b0; waddr = AW'(i % D); raddr = AW'($urandom % D);
      step();
    end

    // R9: reads hopping across tile rows each cycle
    tag = "R9";
    for (int i = 0; i < 120; i++) begin
      raddr = AW'(hop[i % 6]); waddr = AW'(hop[(i + 2) % 6]);
      we = 1'(i % 4 == 1); wdata = W'($urandom);
      step();
    end

    // R7: writes at or above DEPTH, then sweep all valid words
    tag = "R7";
    for (int i = 0; i < 150; i++) begin
      we = 1'b1; waddr = AW'(D + ($urandom % (1024 - D))); raddr = AW'($urandom % D);
      wdata = W'($urandom);
      step();
    end
    we = 1'b0;
    for (int a = 0; a < D; a++) begin
      waddr = AW'(a); raddr = AW'(a);
      step();
    end

    // R8: mid-run reset clears read outputs and keeps contents
    tag = "R8";
    we = 1'b0; rst_n = 1'b0;
    #1;
    check("R8", "sync-thru in reset", q_thru, '0);
    check("R8", "sync-reg in reset", q_reg, '0);
    repeat (2) step();
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      waddr = AW'($urandom % D); raddr = AW'($urandom % D);
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule